// File: doc/BRIEF.md
# Digit-Range BCD/Binary Adder-Subtractor

This block adds or subtracts two 56-bit words held as fourteen 4-bit digits. It works either as a plain binary adder or as a packed-decimal (BCD) adder. The operation covers only a contiguous window of digits, chosen by a low and a high digit index. Digits outside the window come through from operand A unchanged. The carry or borrow leaving the top digit of the window is reported on its own output.

Each digit is computed twice in parallel, once assuming an incoming carry of 0 and once assuming 1. The two carry-outs of a digit act as its generate and propagate terms. A lookahead network turns these into the true carry into every digit, and that carry picks one of the two precomputed results. The arithmetic path is fully combinational. A single register stage on the outputs, selected by a parameter, gives a one-cycle latency from operands to result.

For subtraction the caller drives the carry-in to 1. The carry-out then means "no borrow".

Top module: `bcd_range_addsub`

## Requirements
- R1: With sub=0 and bcd=0, every digit i in the window [lo_idx, hi_idx] of res (bits 4i+3..4i) equals the matching digit of the binary sum of A, B and cin over that window. The carry enters at digit lo_idx.
- R2: With sub=1 and bcd=0, the window holds A + (one's complement of B) + cin. With cin=1 this is A minus B, and cout=1 when no borrow occurred.
- R3: With sub=0 and bcd=1, the window holds the decimal sum of A, B and cin, with every result digit in 0..9 for operand digits in 0..9. A digit carries on when its decimal sum reaches 10.
- R4: With sub=1 and bcd=1, the window holds A + (nine's complement of B) + cin. With cin=1 this is the decimal difference, and cout=1 when no borrow occurred.
- R5: Digits of res outside the window equal the matching digits of A.
- R6: When lo_idx > hi_idx or hi_idx > 13, res equals A and cout is 0.
- R7: cout is the carry leaving digit hi_idx. Carries out of digits above the window do not affect cout.
- R8: cin is the carry into digit lo_idx, whatever the value of lo_idx.
- R9: res and cout are registered. They show the result of the operands present one clock edge earlier. While rst is high at a clock edge, both are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 56 | Operand A (minuend / addend); passes through outside the window |
| opb | input | 56 | Operand B (subtrahend / addend) |
| sub | input | 1 | 1 = subtract, 0 = add |
| bcd | input | 1 | 1 = packed-decimal digits, 0 = binary |
| lo_idx | input | 4 | Lowest digit of the window |
| hi_idx | input | 4 | Highest digit of the window |
| cin | input | 1 | Carry into digit lo_idx (drive 1 to subtract) |
| res | output | 56 | Result word |
| cout | output | 1 | Carry out of digit hi_idx (1 = no borrow when subtracting) |

## Verification
The hardest case to reach is a carry that ripples through a long run of propagating digits. The lookahead must then combine many generate and propagate terms, and every digit has to pick its carry-in-1 copy. This only happens when the operand digits are at their limits over the whole window. Directed cases drive it with all-nines plus one in BCD and all-F plus one in binary across the full range. A case with a carry into the digit just above the window shows that cout ignores it. Randomised windows in all four mode combinations then move the lowest-digit carry mux across every index.

// File: rtl/drsa_pkg.sv
`timescale 1ns/1ps
package drsa_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/drsa_slice.sv
`timescale 1ns/1ps
// One digit copy: complement stage, 4-bit binary add, decimal correction.
module drsa_slice
  import drsa_pkg::*;
#(
  parameter logic FIXED_CI = 1'b0
) (
  input  digit_t a,
  input  digit_t b,
  input  logic   sub,
  input  logic   bcd,
  output digit_t s,
  output logic   co
);
  digit_t     bc;
  logic [4:0] raw;
  logic       fix;

  always_comb begin
    bc = b;
    if (sub) bc = bcd ? (4'd9 - b) : ~b;
    raw = {1'b0, a} + {1'b0, bc} + {4'd0, FIXED_CI};
    fix = 1'b0;
    s   = raw[3:0];
    co  = raw[4];
    if (bcd) begin
      fix = raw[4] | (raw[3:0] > 4'd9);
      s   = fix ? (raw[3:0] + 4'd6) : raw[3:0];
      co  = fix;
    end
  end

  always_comb begin
    if (bcd && (a <= 4'd9) && (b <= 4'd9))
      AST_BCD_DIGIT_LEGAL: assert (s <= 4'd9); // R3
  end
endmodule

// File: rtl/drsa_digit.sv
`timescale 1ns/1ps
// Carry-select digit: two slices with forced carry-in, result picked by carry.
module drsa_digit
  import drsa_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  input  logic   sub,
  input  logic   bcd,
  input  logic   c_in,
  output logic   gen,
  output logic   prop,
  output digit_t y
);
  digit_t s_lo, s_hi;

  drsa_slice #(.FIXED_CI(1'b0)) u_ci0 (
    .a(a), .b(b), .sub(sub), .bcd(bcd), .s(s_lo), .co(gen)
  );
  drsa_slice #(.FIXED_CI(1'b1)) u_ci1 (
    .a(a), .b(b), .sub(sub), .bcd(bcd), .s(s_hi), .co(prop)
  );

  assign y = c_in ? s_hi : s_lo;

  always_comb begin
    if (!bcd || ((a <= 4'd9) && (b <= 4'd9)))
      AST_GEN_IMPLIES_PROP: assert (!gen || prop); // R7
  end
endmodule

// File: rtl/drsa_carry.sv
`timescale 1ns/1ps
// Lookahead: carry into each digit from gen/prop, seeded with cin at lo.
module drsa_carry #(
  parameter int N  = 14,
  parameter int IW = 4
) (
  input  logic [N-1:0]  gen,
  input  logic [N-1:0]  prop,
  input  logic [IW-1:0] lo,
  input  logic [IW-1:0] hi,
  input  logic          cin,
  output logic [N-1:0]  c,
  output logic          cout_top
);
  always_comb begin
    logic run;
    for (int i = 0; i < N; i++) begin
      run = cin;
      for (int j = 0; j < i; j++)
        if (j >= int'(lo)) run = gen[j] | (prop[j] & run);
      c[i] = run;
    end
  end

  always_comb begin
    cout_top = 1'b0;
    for (int i = 0; i < N; i++)
      if (int'(hi) == i) cout_top = gen[i] | (prop[i] & c[i]);
  end
endmodule

// File: rtl/bcd_range_addsub.sv
`timescale 1ns/1ps
module bcd_range_addsub
  import drsa_pkg::*;
#(
  parameter int DIGITS  = 14,
  parameter bit OUT_REG = 1'b1,
  localparam int W      = DIGITS * DIG_W,
  localparam int IW     = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          sub,
  input  logic          bcd,
  input  logic [IW-1:0] lo_idx,
  input  logic [IW-1:0] hi_idx,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  logic [DIGITS-1:0] gen, prop, cdig, in_rng;
  logic [W-1:0]      dig_y, nxt_res;
  logic              cout_top, vld, nxt_cout;

  assign vld = (lo_idx <= hi_idx) && (int'(hi_idx) < DIGITS);

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dig
    drsa_digit u_dig (
      .a   (opa[gi*DIG_W +: DIG_W]),
      .b   (opb[gi*DIG_W +: DIG_W]),
      .sub (sub),
      .bcd (bcd),
      .c_in(cdig[gi]),
      .gen (gen[gi]),
      .prop(prop[gi]),
      .y   (dig_y[gi*DIG_W +: DIG_W])
    );
    assign in_rng[gi] = vld && (lo_idx <= IW'(gi)) && (IW'(gi) <= hi_idx);
    assign nxt_res[gi*DIG_W +: DIG_W] =
      in_rng[gi] ? dig_y[gi*DIG_W +: DIG_W] : opa[gi*DIG_W +: DIG_W];
  end

  drsa_carry #(.N(DIGITS), .IW(IW)) u_carry (
    .gen(gen), .prop(prop), .lo(lo_idx), .hi(hi_idx), .cin(cin),
    .c(cdig), .cout_top(cout_top)
  );

  assign nxt_cout = vld & cout_top;

  if (OUT_REG) begin : g_reg
    logic prim, rst_q;

    always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
        res  <= '0;
        cout <= 1'b0;
        prim <= 1'b0;
      end else begin
        res  <= nxt_res;
        cout <= nxt_cout;
        prim <= 1'b1;
      end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst_q |-> (res == '0) && !cout); // R9

    AST_INVALID_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
      (prim && !$past(vld)) |-> (res == $past(opa)) && !cout); // R6

    AST_ZERO_ADD_IDENTITY: assert property (@(posedge clk) disable iff (rst)
      (prim && $past(vld && !sub && !bcd && !cin && (opb == '0)))
        |-> (res == $past(opa)) && !cout); // R1

    for (genvar gk = 0; gk < DIGITS; gk++) begin : g_chk
      AST_OUTSIDE_PASSES: assert property (@(posedge clk) disable iff (rst)
        (prim && !$past(in_rng[gk]))
          |-> (res[gk*DIG_W +: DIG_W] == $past(opa[gk*DIG_W +: DIG_W]))); // R5
    end
  end else begin : g_comb
    assign res  = nxt_res;
    assign cout = nxt_cout;
  end
endmodule

// File: tb/tb_bcd_range_addsub.sv
`timescale 1ns/1ps
module tb_bcd_range_addsub;
  localparam int DIG = 14;
  localparam int W   = DIG * 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic         sub = 1'b0, bcd = 1'b0, cin = 1'b0;
  logic [3:0]   lo_idx = '0, hi_idx = '0;
  logic [W-1:0] res;
  logic         cout;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bcd_range_addsub dut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .sub(sub), .bcd(bcd),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .cin(cin), .res(res), .cout(cout)
  );

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input logic d, input int lo, input int hi,
                       input logic ci, output logic [W-1:0] r, output logic co);
    int c;
    r  = a;
    co = 1'b0;
    if (lo <= hi && hi < DIG) begin
      c = int'(ci);
      for (int i = lo; i <= hi; i++) begin
        int x, y, t;
        x = int'(a[i*4 +: 4]);
        y = int'(b[i*4 +: 4]);
        if (d) begin
          if (s) y = 9 - y;
          t = x + y + c;
          if (t >= 10) begin t = t - 10; c = 1; end else c = 0;
        end else begin
          if (s) y = 15 - y;
          t = x + y + c;
          c = t / 16;
          t = t % 16;
        end
        r[i*4 +: 4] = t[3:0];
      end
      co = c[0];
    end
  endtask

  task automatic check(input string tag, input logic [W-1:0] er, input logic ec);
    checks++;
    if (res !== er || cout !== ec) begin
      errors++;
      $display("FAIL %s: actual res=%h cout=%b expected res=%h cout=%b",
               tag, res, cout, er, ec);
    end
  endtask

  task automatic run(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic s, input logic d, input int lo, input int hi,
                     input logic ci);
    logic [W-1:0] er;
    logic         ec;
    @(negedge clk);
    opa = a; opb = b; sub = s; bcd = d; cin = ci;
    lo_idx = 4'(lo); hi_idx = 4'(hi);
    model(a, b, s, d, lo, hi, ci, er, ec);
    @(negedge clk);
    check(tag, er, ec);
  endtask

  function automatic logic [W-1:0] rnd_word(input logic d);
    logic [W-1:0] w;
    for (int i = 0; i < DIG; i++)
      w[i*4 +: 4] = d ? 4'($urandom % 10) : 4'($urandom % 16);
    return w;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    opa = '1; opb = '1; hi_idx = 4'd13; cin = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset", '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_bin_add();
    run("R1 full", 56'h0123456789ABCD, 56'h00000000001111, 0, 0, 0, 13, 0);
    run("R1 window", 56'h0123456789ABCD, 56'h0F0F0F0F0F0F0F, 0, 0, 3, 9, 1);
    run("R1 all-F plus one", {W{1'b1}}, 56'h1, 0, 0, 0, 13, 0);
  endtask

  task automatic t_bin_sub();
    run("R2 no borrow", 56'h00000000009000, 56'h00000000000123, 1, 0, 0, 13, 1);
    run("R2 borrow", 56'h00000000000001, 56'h00000000000002, 1, 0, 0, 13, 1);
  endtask

  task automatic t_bcd_add();
    run("R3 sum", 56'h00000000001234, 56'h00000000005678, 0, 1, 0, 13, 0);
    run("R3 all nines", 56'h99999999999999, 56'h00000000000001, 0, 1, 0, 13, 0);
    run("R3 zeros", '0, '0, 0, 1, 0, 13, 0);
  endtask

  task automatic t_bcd_sub();
    run("R4 no borrow", 56'h00000000005000, 56'h00000000000001, 1, 1, 0, 13, 1);
    run("R4 borrow", 56'h00000000000003, 56'h00000000000007, 1, 1, 0, 13, 1);
    run("R4 zero minus zero", '0, '0, 1, 1, 0, 13, 1);
  endtask

  task automatic t_outside();
    run("R5 outside kept", 56'hABCDEF01234567, 56'h99999999999999, 0, 0, 4, 7, 1);
    run("R5 single digit", 56'h77777777777777, 56'h11111111111111, 0, 1, 13, 13, 0);
  endtask

  task automatic t_invalid();
    run("R6 lo>hi", 56'h12345678901234, 56'h99999999999999, 0, 0, 9, 3, 1);
    run("R6 hi=14", 56'h12345678901234, 56'hFFFFFFFFFFFFFF, 0, 0, 0, 14, 1);
    run("R6 hi=15", 56'h12345678901234, 56'hFFFFFFFFFFFFFF, 1, 1, 2, 15, 1);
  endtask

  task automatic t_cout_top();
    run("R7 carry at top", 56'h0000000F000000, 56'h00000001000000, 0, 0, 2, 6, 0);
    run("R7 carry above ignored", 56'h000000F0000000, 56'h00000010000000, 0, 0, 2, 6, 0);
  endtask

  task automatic t_cin_entry();
    run("R8 cin at lo=6", '0, '0, 0, 0, 6, 6, 1);
    run("R8 cin at lo=0", '0, '0, 0, 1, 0, 0, 1);
    run("R8 ripple from lo", 56'h00009999000000, '0, 0, 1, 6, 10, 1);
  endtask

  task automatic t_latency();
    logic [W-1:0] er0, er1;
    logic         ec0, ec1;
    run("R9 setup", 56'h5, 56'h3, 0, 0, 0, 13, 0);
    model(56'h5, 56'h3, 0, 0, 0, 13, 0, er0, ec0);
    model(56'h9, 56'h9, 0, 1, 0, 13, 0, er1, ec1);
    @(negedge clk);
    opa = 56'h9; opb = 56'h9; bcd = 1'b1;
    #4;
    check("R9 before edge", er0, ec0);
    @(negedge clk);
    check("R9 after edge", er1, ec1);
  endtask

  task automatic t_random();
    string tags[4] = '{"R1 random", "R2 random", "R3 random", "R4 random"};
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 60; k++) begin
        int lo, hi;
        logic d, s;
        s  = m[0];
        d  = m[1];
        lo = int'($urandom % 14);
        hi = lo + int'($urandom % (14 - lo));
        run(tags[m], rnd_word(d), rnd_word(d), s, d, lo, hi,
            s ? 1'b1 : 1'($urandom % 2));
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_bin_add();
    t_bin_sub();
    t_bcd_add();
    t_bcd_sub();
    t_outside();
    t_invalid();
    t_cout_top();
    t_cin_entry();
    t_latency();
    t_random();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=complete");
      finish_run();
    end
  end
endmodule